// File: doc/BRIEF.md
# Setup Packet Capture Buffer

This block holds the eight data bytes of the setup stage of a USB control transfer. The bytes come in on a byte-wide write port from the USB side, and a CPU then reads them one at a time through a byte-wide read port. A start strobe from the USB side opens each reception. After the last byte has been written, a ready flag tells the CPU that a whole setup packet can be read.

A new setup packet must never be lost, so the USB side always wins. A start strobe ends any CPU read sequence that is still running. A read made in the same cycle as the start strobe, and every read after it until the new packet is complete, is marked invalid. When a read sequence is cut off, a one-cycle abort pulse is given. The CPU is expected to read each packet as one full run of eight bytes. The read pointer returns to byte 0 only when a packet completes, when the eighth byte is read, or when a reception starts.

Top module: `setup_capture_buf`

## Requirements
- R1: While reset is held and in the first cycle after it, `setup_ready`, `rd_valid` and `rd_abort` are 0 and `rd_data` is 0.
- R2: After `rx_start`, `setup_ready` becomes 1 in the cycle after the eighth accepted `rx_wr` byte, and only then.
- R3: Each `rd_req` while `setup_ready` is 1 and `rx_start` is 0 gives `rd_valid`=1 in the next cycle. `rd_data` then carries the packet's bytes in write order, starting at byte 0.
- R4: The eighth valid read clears `setup_ready` in the next cycle. Otherwise `setup_ready` drops only on `rx_start`.
- R5: A `rd_req` while `setup_ready` is 0 gives `rd_valid`=0 and `rd_data`=0 in the next cycle, and it does not move the read pointer.
- R6: `rx_start` clears `setup_ready` in the next cycle. A `rd_req` in the same cycle as `rx_start` is invalid.
- R7: `rd_abort` is 1 for exactly one cycle, the cycle after an `rx_start` that meets a ready packet with a partly finished read sequence or with a `rd_req` in the same cycle. It is 0 in every other case.
- R8: A `rx_wr` with no open reception is ignored and leaves the stored bytes unchanged. Writes before any `rx_start`, and writes after the eighth byte of a packet, fall in this case.
- R9: A `rx_wr` in the same cycle as `rx_start` stores byte 0 of the new packet.
- R10: After a read sequence is cut off, the next complete packet is read from its byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_start | input | 1 | Strobe that opens a new setup reception |
| rx_wr | input | 1 | USB-side byte write strobe |
| rx_data | input | 8 | USB-side byte to store |
| rd_req | input | 1 | CPU read strobe |
| rd_data | output | 8 | Byte returned one cycle after `rd_req`, or 0 when invalid |
| rd_valid | output | 1 | The byte returned one cycle after `rd_req` is valid |
| setup_ready | output | 1 | A complete setup packet is waiting to be read |
| rd_abort | output | 1 | One-cycle pulse when a read sequence is preempted |

## Verification
The bench builds the block with its defaults, eight bytes of eight bits. At that size every read-pointer position can be interrupted. The bench sweeps cut-off reads after 1 to 7 bytes, and a read that collides with the start strobe. Each sweep is followed by a fresh packet that must read back from byte 0. Sixteen packets with arithmetic byte patterns alternate between a start strobe alone and a start strobe paired with the first write. The bench also covers writes with no open reception, and reads while no packet is ready.

// File: rtl/setup_buf_pkg.sv
// Package: shared defaults and helpers for the setup packet capture buffer.
// Assumes: users size the buffer through the top-level parameters only.
package setup_buf_pkg;
    localparam int unsigned SETUP_BYTES_DEF = 8;
    localparam int unsigned BYTE_W_DEF      = 8;

    // Width of a pointer able to index the given number of bytes.
    function automatic int unsigned idx_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/setup_rx_ctrl.sv
// Module: USB-side write sequencer. It tracks whether a reception is open
// and which byte comes next. It flags the write that completes a packet.
// Assumes: rx_start opens a reception. A write in the same cycle as the
// start goes to byte 0. Writes are accepted only while a reception is open.
module setup_rx_ctrl #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_start,
    input  logic             rx_wr,
    output logic             wr_fire,
    output logic [PTR_W-1:0] wr_idx,
    output logic             pkt_done
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic             rx_open_q;
    logic [PTR_W-1:0] wr_ptr_q;
    logic             open_eff;

    // Effective state for this cycle: a start strobe reopens at byte 0.
    always_comb begin
        open_eff = rx_start | rx_open_q;
        wr_idx   = rx_start ? '0 : wr_ptr_q;
        wr_fire  = rx_wr & open_eff;
        pkt_done = wr_fire && (wr_idx == LAST_IDX);
    end

    // Reception state: open on start, close once the last byte is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_open_q <= 1'b0;
            wr_ptr_q  <= '0;
        end else if (pkt_done) begin
            rx_open_q <= 1'b0;
            wr_ptr_q  <= '0;
        end else if (wr_fire) begin
            rx_open_q <= 1'b1;
            wr_ptr_q  <= wr_idx + 1'b1;
        end else if (rx_start) begin
            rx_open_q <= 1'b1;
            wr_ptr_q  <= '0;
        end
    end
endmodule

// File: rtl/setup_store.sv
// Module: byte storage for one setup packet, with one write port and a
// combinational read port.
// Assumes: the write side gives one byte index per cycle, and the read
// index is always below DEPTH.
module setup_store #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [BYTE_W-1:0] cell_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // One byte cell: loaded when the write addresses this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q[g] <= '0;
            end else if (wr_fire && (wr_idx == PTR_W'(g))) begin
                cell_q[g] <= wr_byte;
            end
        end
    end

    // Read mux: pick the byte at the CPU read pointer.
    always_comb begin
        rd_byte = cell_q[rd_idx];
    end
endmodule

// File: rtl/setup_rd_ctrl.sv
// Module: CPU-side read sequencer. It owns the ready flag and the read
// pointer, forms the registered read response, and raises the abort pulse
// when a start strobe preempts a read sequence.
// Assumes: pkt_done and a ready packet are never present together, except
// when a start and a completing write share a cycle, where pkt_done wins.
module setup_rd_ctrl #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              pkt_done,
    input  logic              rd_req,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [PTR_W-1:0]  rd_idx,
    output logic              ready,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_abort
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] rd_ptr_q;
    logic             ready_q;
    logic             rd_ok;
    logic             rd_last;
    logic             preempt;

    // Read qualification: the USB side wins over any CPU read.
    always_comb begin
        rd_ok   = rd_req & ready_q & ~rx_start;
        rd_last = rd_ok && (rd_ptr_q == LAST_IDX);
        preempt = rx_start & ready_q & (rd_req | (rd_ptr_q != '0));
        rd_idx  = rd_ptr_q;
        ready   = ready_q;
    end

    // Ready flag: set by a completed packet, cleared by start or last read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else if (pkt_done) begin
            ready_q <= 1'b1;
        end else if (rx_start || rd_last) begin
            ready_q <= 1'b0;
        end
    end

    // Read pointer: rewinds on start, on a new packet or after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
        end else if (rx_start || pkt_done || rd_last) begin
            rd_ptr_q <= '0;
        end else if (rd_ok) begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
        end
    end

    // Registered read response and abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_abort <= 1'b0;
        end else begin
            rd_valid <= rd_ok;
            rd_data  <= rd_ok ? rd_byte : '0;
            rd_abort <= preempt;
        end
    end
endmodule

// File: rtl/setup_capture_buf.sv
// Module: top of the setup packet capture buffer. It joins the USB-side
// write sequencer, the byte storage and the CPU-side read sequencer.
// Assumes: one clock domain for both sides, and a synchronous active-low
// reset.
module setup_capture_buf
    import setup_buf_pkg::*;
#(
    parameter int unsigned DEPTH  = SETUP_BYTES_DEF,
    parameter int unsigned BYTE_W = BYTE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_wr,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rd_req,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              setup_ready,
    output logic              rd_abort
);
    localparam int unsigned PTR_W = idx_width(DEPTH);

    logic             wr_fire;
    logic             pkt_done;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic [BYTE_W-1:0] rd_byte;

    setup_rx_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_start (rx_start),
        .rx_wr    (rx_wr),
        .wr_fire  (wr_fire),
        .wr_idx   (wr_idx),
        .pkt_done (pkt_done)
    );

    setup_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .wr_idx  (wr_idx),
        .wr_byte (rx_data),
        .rd_idx  (rd_idx),
        .rd_byte (rd_byte)
    );

    setup_rd_ctrl #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .PTR_W(PTR_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_start (rx_start),
        .pkt_done (pkt_done),
        .rd_req   (rd_req),
        .rd_byte  (rd_byte),
        .rd_idx   (rd_idx),
        .ready    (setup_ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_abort (rd_abort)
    );
endmodule

// File: rtl/setup_capture_buf_chk.sv
// Module: protocol checker for the setup packet capture buffer. It only
// observes the top-level ports and is attached with a bind statement.
module setup_capture_buf_chk #(
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_start,
    input logic              rx_wr,
    input logic              rd_req,
    input logic [BYTE_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              setup_ready,
    input logic              rd_abort
);
    assert_ready_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_ready) |-> $past(rx_wr));

    assert_no_req_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    assert_ready_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_ready && !rx_start && !rd_req) |=> setup_ready);

    assert_idle_read_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !setup_ready) |=> !rd_valid);

    assert_invalid_data_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    assert_start_clears_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> (!setup_ready && !rd_valid));

    assert_abort_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_abort |=> !rd_abort);

    assert_abort_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_abort |-> ($past(rx_start) && $past(setup_ready)));
endmodule

bind setup_capture_buf setup_capture_buf_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_start    (rx_start),
    .rx_wr       (rx_wr),
    .rd_req      (rd_req),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .setup_ready (setup_ready),
    .rd_abort    (rd_abort)
);

// File: tb/sim_setup_capture_buf.sv
module sim_setup_capture_buf;
    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 8;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_start = 1'b0;
    logic       rx_wr = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rd_req = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       setup_ready;
    logic       rd_abort;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    setup_capture_buf u0 (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_wr(rx_wr),
        .rx_data(rx_data), .rd_req(rd_req), .rd_data(rd_data),
        .rd_valid(rd_valid), .setup_ready(setup_ready), .rd_abort(rd_abort)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input int p, input int i);
        return 8'((p * 37 + i * 11 + 5) & 255);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled 1 unit after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Send one full packet; paired puts the first write with the start strobe.
    task automatic send_pkt(input int p, input bit paired);
        int first;
        rx_start = 1'b1;
        rx_wr    = paired;
        rx_data  = pat(p, 0);
        tick();
        rx_start = 1'b0;
        first = paired ? 1 : 0;
        for (int i = first; i < NBYTES; i++) begin
            check("R2", "ready before last write", setup_ready, 0);
            rx_wr   = 1'b1;
            rx_data = pat(p, i);
            tick();
        end
        rx_wr = 1'b0;
        check("R2", "ready after last write", setup_ready, 1);
    endtask

    task automatic read_one(input string req, input int exp_valid, input int exp_data);
        rd_req = 1'b1;
        tick();
        rd_req = 1'b0;
        check(req, "rd_valid", rd_valid, exp_valid);
        check(req, "rd_data", rd_data, exp_data);
    endtask

    initial begin
        // R1 reset state
        tick(); tick();
        check("R1", "ready in reset", setup_ready, 0);
        check("R1", "abort in reset", rd_abort, 0);
        rst_n = 1'b1;
        tick();
        check("R1", "ready after reset", setup_ready, 0);
        check("R1", "valid after reset", rd_valid, 0);
        check("R1", "data after reset", rd_data, 0);

        // R8 writes with no open reception are ignored; R5 idle reads invalid
        for (int i = 0; i < NBYTES + 2; i++) begin
            rx_wr = 1'b1; rx_data = 8'hEE; tick();
        end
        rx_wr = 1'b0;
        check("R8", "ready after stray writes", setup_ready, 0);
        read_one("R5", 0, 0);

        // R3 R4 R9: sweep packets, alternating paired start
        for (int p = 0; p < 16; p++) begin
            send_pkt(p, p[0]);
            for (int i = 0; i < NBYTES; i++) begin
                check(p[0] ? "R9" : "R3", "ready during read", setup_ready, 1);
                read_one("R3", 1, pat(p, i));
            end
            check("R4", "ready after 8th read", setup_ready, 0);
            read_one("R5", 0, 0);
            check("R7", "no abort on clean start", rd_abort, 0);
        end

        // R8 writes after a completed packet leave its bytes unchanged
        send_pkt(40, 1'b0);
        for (int i = 0; i < 3; i++) begin
            rx_wr = 1'b1; rx_data = 8'h5A; tick();
        end
        rx_wr = 1'b0;
        for (int i = 0; i < NBYTES; i++) read_one("R8", 1, pat(40, i));

        // R7 R10: cut off a read sequence after k bytes
        for (int k = 1; k < NBYTES; k++) begin
            send_pkt(50 + k, 1'b0);
            for (int i = 0; i < k; i++) read_one("R3", 1, pat(50 + k, i));
            rx_start = 1'b1; tick(); rx_start = 1'b0;
            check("R7", "abort after partial read", rd_abort, 1);
            check("R6", "ready cleared by start", setup_ready, 0);
            tick();
            check("R7", "abort lasts one cycle", rd_abort, 0);
            for (int i = 0; i < NBYTES; i++) begin
                rx_wr = 1'b1; rx_data = pat(60 + k, i); tick();
            end
            rx_wr = 1'b0;
            for (int i = 0; i < NBYTES; i++) read_one("R10", 1, pat(60 + k, i));
        end

        // R6 R7: read colliding with start at byte 0 is invalid and aborts
        send_pkt(70, 1'b0);
        rx_start = 1'b1; rd_req = 1'b1; tick();
        rx_start = 1'b0; rd_req = 1'b0;
        check("R6", "collided read invalid", rd_valid, 0);
        check("R7", "abort on collided read", rd_abort, 1);
        // R5: reads during reception invalid and do not move the pointer
        read_one("R5", 0, 0);
        for (int i = 0; i < NBYTES; i++) begin
            rx_wr = 1'b1; rx_data = pat(71, i); tick();
        end
        rx_wr = 1'b0;
        for (int i = 0; i < NBYTES; i++) read_one("R10", 1, pat(71, i));

        // R7: start with no ready packet gives no abort
        rx_start = 1'b1; rd_req = 1'b1; tick();
        rx_start = 1'b0; rd_req = 1'b0;
        check("R7", "no abort without ready packet", rd_abort, 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule